// File: doc/BRIEF.md
# Verify-Mode Read Responder

This block is the target-side responder for reading back non-volatile contents while the device is held in reset. A host drives the device reset line high, holds the program-strobe line low, places an 8-bit mode code on a mode port and a 16-bit address on two byte ports (high and low). After a fixed settle time, the block drives the selected byte on its data port. The byte can come from code memory, the configuration bytes, the lock status or the fixed signature bytes.

The block does not read storage contents itself. The code memory is reached through an address output and a byte input. The configuration bytes, the lock bits, the revision choice and a code-read permission flag come in as inputs. Entry into the read mode is guarded. The program strobe must sit low for a fixed number of clocks while reset is held before any mode code is taken. Every change of mode or address restarts the settle timer, and the data port stays released until the timer expires.

Top module: `vfy_read_port`

## Requirements
- R1: After the block's own synchronous reset `rst`, `data_oe` is 0 and `data_out` is 00h.
- R2: `data_oe` rises only after `chip_rst` has been 1 and `psen_n` 0 on 14 consecutive rising edges. If either condition breaks earlier, the count starts again from zero.
- R3: `data_oe` rises on the 48th rising edge, counting from the first edge that samples a new mode or address value, or from the edge that completes entry. Any mode or address change clears `data_oe` at the first edge that samples it.
- R4: Mode 28h with address {addr_hi,addr_lo} in 0000h..3FFFh returns `code_rd_data`. `code_rd_addr` carries the low 14 address bits.
- R5: Mode 28h returns FFh when `code_read_ok` is 0, or when the address is 4000h or above.
- R6: Mode 29h at 0080h..0083h returns configuration byte n = address[1:0], taken from `cfg_bytes[8n+7:8n]`.
- R7: Mode 29h returns 58h at 0030h, 40h at 0031h and FBh at 0060h. At 0061h it returns FEh when `rev_second` is 1 and FFh when it is 0.
- R8: Mode 2Bh at address 0000h returns {5'b11111, lock_bits[2:0]}.
- R9: Any mode other than 28h, 29h and 2Bh, and any unmapped address under a known mode, returns FFh after the same latency.
- R10: Dropping `chip_rst` or raising `psen_n` clears `data_oe` at the first edge that samples it. A full 14-clock entry is then needed again.
- R11: `data_out` is 00h whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| chip_rst | input | 1 | Device reset line level, 1 = held in reset |
| psen_n | input | 1 | Program strobe line, active low |
| mode_in | input | 8 | Verify mode code |
| addr_hi | input | 8 | Address bits 15..8 |
| addr_lo | input | 8 | Address bits 7..0 |
| code_read_ok | input | 1 | 1 = security level allows code readback |
| code_rd_data | input | 8 | Byte from code memory at `code_rd_addr` |
| cfg_bytes | input | 32 | Four configuration bytes, byte n at bits 8n+7:8n |
| lock_bits | input | 3 | Current lock bit values |
| rev_second | input | 1 | Selects the second revision signature value |
| code_rd_addr | output | 14 | Code memory read address |
| data_out | output | 8 | Read-back byte |
| data_oe | output | 1 | Data port drive enable, 0 = released |

## Verification
A wrong entry counter shows up as `data_oe` rising too early after a broken strobe sequence, or never rising at all. The bench sees this one settle period after the expected rise. A wrong settle counter moves the rise edge by one or more cycles. The bench catches it because it checks both the cycle just before the rise and the rise cycle itself. A decode fault shows up as a wrong byte at the first valid cycle. Stale hold state shows up as `data_oe` still high on the cycle after an address change, a reset drop or a strobe release.

// File: rtl/vfy_pkg.sv
package vfy_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [BYTE_W-1:0] MODE_CODE = 8'h28;
  localparam logic [BYTE_W-1:0] MODE_CFG  = 8'h29;
  localparam logic [BYTE_W-1:0] MODE_LOCK = 8'h2B;

  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

  localparam logic [ADDR_W-1:0] CFG_BASE  = 16'h0080;
  localparam logic [ADDR_W-1:0] SIG_A0    = 16'h0030;
  localparam logic [ADDR_W-1:0] SIG_A1    = 16'h0031;
  localparam logic [ADDR_W-1:0] SIG_A2    = 16'h0060;
  localparam logic [ADDR_W-1:0] SIG_A3    = 16'h0061;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 16'h0000;

  localparam logic [BYTE_W-1:0] SIG_D0     = 8'h58;
  localparam logic [BYTE_W-1:0] SIG_D1     = 8'h40;
  localparam logic [BYTE_W-1:0] SIG_D2     = 8'hFB;
  localparam logic [BYTE_W-1:0] SIG_REV_A  = 8'hFF;
  localparam logic [BYTE_W-1:0] SIG_REV_B  = 8'hFE;
endpackage

// File: rtl/vfy_entry_gate.sv
module vfy_entry_gate #(
  parameter int ENTRY_CLKS = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_rst,
  input  logic psen_n,
  output logic entry_ok
);
  localparam int CW = $clog2(ENTRY_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          cond;

  assign cond     = chip_rst && !psen_n;
  assign entry_ok = armed_q && cond;

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      if (cnt_q == CW'(ENTRY_CLKS - 1)) armed_q <= 1'b1;
      else                              cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vfy_settle_timer.sv
module vfy_settle_timer #(
  parameter int SETTLE_CLKS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic armed_i,
  input  logic restart_i,
  output logic load_o,
  output logic keep_o
);
  localparam int CW = $clog2(SETTLE_CLKS + 1);

  logic [CW-1:0] scnt_q;
  logic          done_q;
  logic          run;

  assign run    = armed_i && !restart_i;
  assign load_o = run && !done_q && (scnt_q == CW'(SETTLE_CLKS - 1));
  assign keep_o = run && done_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      scnt_q <= CW'(1);
      done_q <= 1'b0;
    end else if (load_o) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      scnt_q <= scnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vfy_byte_select.sv
module vfy_byte_select
  import vfy_pkg::*;
#(
  parameter int CODE_AW = 14,
  parameter int CFG_N   = 4
) (
  input  logic [BYTE_W-1:0]       mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTE_W-1:0]       code_i,
  input  logic                    code_ok_i,
  input  logic [BYTE_W*CFG_N-1:0] cfg_i,
  input  logic [2:0]              lock_i,
  input  logic                    rev_second_i,
  output logic [BYTE_W-1:0]       byte_o
);
  localparam int CFG_IW = (CFG_N > 1) ? $clog2(CFG_N) : 1;

  logic [BYTE_W-1:0] cfg_arr [CFG_N];
  logic [BYTE_W-1:0] cfg_sel;
  logic              cfg_hit;

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    assign cfg_arr[g] = cfg_i[BYTE_W*g +: BYTE_W];
  end

  assign cfg_hit = (addr_i[ADDR_W-1:CFG_IW] == CFG_BASE[ADDR_W-1:CFG_IW])
                && (32'(addr_i[CFG_IW-1:0]) < CFG_N);
  assign cfg_sel = cfg_arr[addr_i[CFG_IW-1:0]];

  always_comb begin
    byte_o = FILL_BYTE;
    case (mode_i)
      MODE_CODE: begin
        if (addr_i[ADDR_W-1:CODE_AW] == '0 && code_ok_i) byte_o = code_i;
      end
      MODE_CFG: begin
        if (cfg_hit) byte_o = cfg_sel;
        else begin
          case (addr_i)
            SIG_A0:  byte_o = SIG_D0;
            SIG_A1:  byte_o = SIG_D1;
            SIG_A2:  byte_o = SIG_D2;
            SIG_A3:  byte_o = rev_second_i ? SIG_REV_B : SIG_REV_A;
            default: byte_o = FILL_BYTE;
          endcase
        end
      end
      MODE_LOCK: begin
        if (addr_i == LOCK_ADDR) byte_o = {5'b11111, lock_i};
      end
      default: byte_o = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/vfy_read_port.sv
module vfy_read_port
  import vfy_pkg::*;
#(
  parameter int ENTRY_CLKS  = 14,
  parameter int SETTLE_CLKS = 48,
  parameter int CODE_AW     = 14,
  parameter int CFG_N       = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chip_rst,
  input  logic                    psen_n,
  input  logic [7:0]              mode_in,
  input  logic [7:0]              addr_hi,
  input  logic [7:0]              addr_lo,
  input  logic                    code_read_ok,
  input  logic [7:0]              code_rd_data,
  input  logic [8*CFG_N-1:0]      cfg_bytes,
  input  logic [2:0]              lock_bits,
  input  logic                    rev_second,
  output logic [CODE_AW-1:0]      code_rd_addr,
  output logic [7:0]              data_out,
  output logic                    data_oe
);
  logic [BYTE_W-1:0] mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_now;
  logic              restart;
  logic              entry_ok;
  logic              load;
  logic              keep;
  logic [BYTE_W-1:0] sel_byte;

  assign addr_now     = {addr_hi, addr_lo};
  assign restart      = (mode_in != mode_q) || (addr_now != addr_q);
  assign code_rd_addr = addr_q[CODE_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      addr_q <= '0;
    end else begin
      mode_q <= mode_in;
      addr_q <= addr_now;
    end
  end

  vfy_entry_gate #(.ENTRY_CLKS(ENTRY_CLKS)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .chip_rst (chip_rst),
    .psen_n   (psen_n),
    .entry_ok (entry_ok)
  );

  vfy_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .armed_i   (entry_ok),
    .restart_i (restart),
    .load_o    (load),
    .keep_o    (keep)
  );

  vfy_byte_select #(.CODE_AW(CODE_AW), .CFG_N(CFG_N)) u_sel (
    .mode_i       (mode_q),
    .addr_i       (addr_q),
    .code_i       (code_rd_data),
    .code_ok_i    (code_read_ok),
    .cfg_i        (cfg_bytes),
    .lock_i       (lock_bits),
    .rev_second_i (rev_second),
    .byte_o       (sel_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else if (load) begin
      data_oe  <= 1'b1;
      data_out <= sel_byte;
    end else if (!keep) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end
  end
endmodule

// File: rtl/vfy_read_port_chk.sv
module vfy_read_port_chk #(
  parameter int ENTRY_CLKS  = 14,
  parameter int SETTLE_CLKS = 48
) (
  input logic       clk,
  input logic       rst,
  input logic       chip_rst,
  input logic       psen_n,
  input logic [7:0] mode_in,
  input logic [7:0] addr_hi,
  input logic [7:0] addr_lo,
  input logic [7:0] data_out,
  input logic       data_oe
);
  localparam int EW = $clog2(ENTRY_CLKS + 1);
  localparam int SW = $clog2(SETTLE_CLKS + 1);

  logic [EW-1:0] ent_cnt;
  logic [SW-1:0] quiet_cnt;
  logic [7:0]    prev_mode;
  logic [15:0]   prev_addr;
  logic          cond;
  logic          steady;

  assign cond   = chip_rst && !psen_n;
  assign steady = (mode_in == prev_mode) && ({addr_hi, addr_lo} == prev_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_cnt   <= '0;
      quiet_cnt <= '0;
      prev_mode <= '0;
      prev_addr <= '0;
    end else begin
      prev_mode <= mode_in;
      prev_addr <= {addr_hi, addr_lo};
      if (!cond)                           ent_cnt <= '0;
      else if (ent_cnt != EW'(ENTRY_CLKS)) ent_cnt <= ent_cnt + 1'b1;
      if (!cond || !steady)                     quiet_cnt <= '0;
      else if (quiet_cnt != SW'(SETTLE_CLKS))   quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assert_entry_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> ent_cnt == EW'(ENTRY_CLKS));

  assert_settle_time_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> quiet_cnt >= SW'(SETTLE_CLKS - 1));

  assert_change_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mode_in) || !$stable(addr_hi) || !$stable(addr_lo)) |=> !data_oe);

  assert_sig_first_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_oe) && $past(mode_in) == 8'h29 && $past({addr_hi, addr_lo}) == 16'h0030)
    |-> data_out == 8'h58);

  assert_unknown_fill_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_oe) && $past(mode_in) != 8'h28 && $past(mode_in) != 8'h29
     && $past(mode_in) != 8'h2B) |-> data_out == 8'hFF);

  assert_rst_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(chip_rst) || $rose(psen_n)) |=> !data_oe);

  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == 8'h00);
endmodule

bind vfy_read_port vfy_read_port_chk #(
  .ENTRY_CLKS (ENTRY_CLKS),
  .SETTLE_CLKS(SETTLE_CLKS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .chip_rst (chip_rst),
  .psen_n   (psen_n),
  .mode_in  (mode_in),
  .addr_hi  (addr_hi),
  .addr_lo  (addr_lo),
  .data_out (data_out),
  .data_oe  (data_oe)
);

// File: tb/vfy_read_port_tb.sv
module vfy_read_port_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_rst = 1'b0;
  logic        psen_n = 1'b1;
  logic [7:0]  mode_in = 8'h00;
  logic [7:0]  addr_hi = 8'h00;
  logic [7:0]  addr_lo = 8'h00;
  logic        code_read_ok = 1'b1;
  logic [7:0]  code_rd_data;
  logic [31:0] cfg_bytes = 32'hA1B2C3D4;
  logic [2:0]  lock_bits = 3'b011;
  logic        rev_second = 1'b0;
  logic [13:0] code_rd_addr;
  logic [7:0]  data_out;
  logic        data_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  assign code_rd_data = mem_f(code_rd_addr);

  vfy_read_port dut_i (
    .clk          (clk),
    .rst          (rst),
    .chip_rst     (chip_rst),
    .psen_n       (psen_n),
    .mode_in      (mode_in),
    .addr_hi      (addr_hi),
    .addr_lo      (addr_lo),
    .code_read_ok (code_read_ok),
    .code_rd_data (code_rd_data),
    .cfg_bytes    (cfg_bytes),
    .lock_bits    (lock_bits),
    .rev_second   (rev_second),
    .code_rd_addr (code_rd_addr),
    .data_out     (data_out),
    .data_oe      (data_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] m, input logic [15:0] a);
    @(negedge clk);
    mode_in = m;
    addr_hi = a[15:8];
    addr_lo = a[7:0];
  endtask

  // oe must be low after n-1 edges and high with the byte after edge n
  task automatic wait_valid(input int n, input logic [7:0] exp, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 oe low before settle"}, 16'(data_oe), 16'h0);
    chk({tag, " R11 idle bus"}, 16'(data_out), 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 oe high at settle"}, 16'(data_oe), 16'h1);
    chk({tag, " data"}, 16'(data_out), 16'(exp));
  endtask

  task automatic arm(input logic [7:0] m, input logic [15:0] a);
    @(negedge clk);
    psen_n = 1'b1;
    chip_rst = 1'b1;
    @(negedge clk);
    psen_n = 1'b0;
    mode_in = m;
    addr_hi = a[15:8];
    addr_lo = a[7:0];
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 oe after reset", 16'(data_oe), 16'h0);
    chk("R1 data after reset", 16'(data_out), 16'h0);
  endtask

  task automatic t_short_entry;
    @(negedge clk);
    chip_rst = 1'b1;
    psen_n = 1'b0;
    mode_in = 8'h28;
    addr_hi = 8'h00;
    addr_lo = 8'h00;
    repeat (13) @(posedge clk);
    @(negedge clk);
    psen_n = 1'b1;
    @(negedge clk);
    psen_n = 1'b0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R2 broken entry restarts count", 16'(data_oe), 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 full entry then settle", 16'(data_oe), 16'h1);
    chk("R4 code byte 0000h", 16'(data_out), 16'(mem_f(14'h0000)));
  endtask

  task automatic t_code;
    arm(8'h28, 16'h1234);
    wait_valid(61, mem_f(14'h1234), "R4 code 1234h");
    chk("R4 code address", 16'(code_rd_addr), 16'h1234);
    apply(8'h28, 16'h3FFF);
    @(posedge clk);
    @(negedge clk);
    chk("R3 change drops oe", 16'(data_oe), 16'h0);
    chk("R11 data cleared", 16'(data_out), 16'h0);
    wait_valid(47, mem_f(14'h3FFF), "R4 code 3FFFh");
  endtask

  task automatic t_gating;
    apply(8'h28, 16'h4000);
    wait_valid(48, 8'hFF, "R5 out of range");
    @(negedge clk);
    code_read_ok = 1'b0;
    apply(8'h28, 16'h0100);
    wait_valid(48, 8'hFF, "R5 read blocked");
    @(negedge clk);
    code_read_ok = 1'b1;
  endtask

  task automatic t_cfg;
    apply(8'h29, 16'h0080);
    wait_valid(48, 8'hD4, "R6 cfg 0");
    apply(8'h29, 16'h0082);
    wait_valid(48, 8'hB2, "R6 cfg 2");
    apply(8'h29, 16'h0083);
    wait_valid(48, 8'hA1, "R6 cfg 3");
  endtask

  task automatic t_sig;
    apply(8'h29, 16'h0030);
    wait_valid(48, 8'h58, "R7 sig 30h");
    apply(8'h29, 16'h0031);
    wait_valid(48, 8'h40, "R7 sig 31h");
    apply(8'h29, 16'h0060);
    wait_valid(48, 8'hFB, "R7 sig 60h");
    apply(8'h29, 16'h0061);
    wait_valid(48, 8'hFF, "R7 rev first");
    @(negedge clk);
    rev_second = 1'b1;
    apply(8'h29, 16'h0030);
    apply(8'h29, 16'h0061);
    wait_valid(48, 8'hFE, "R7 rev second");
  endtask

  task automatic t_lock;
    apply(8'h2B, 16'h0000);
    wait_valid(48, 8'hFB, "R8 lock 011");
    @(negedge clk);
    lock_bits = 3'b111;
    apply(8'h2B, 16'h0001);
    apply(8'h2B, 16'h0000);
    wait_valid(48, 8'hFF, "R8 lock 111");
  endtask

  task automatic t_unmapped;
    apply(8'h2A, 16'h0000);
    wait_valid(48, 8'hFF, "R9 unknown mode");
    apply(8'h29, 16'h0084);
    wait_valid(48, 8'hFF, "R9 cfg gap");
    apply(8'h2B, 16'h0001);
    wait_valid(48, 8'hFF, "R9 lock gap");
  endtask

  task automatic t_drop;
    apply(8'h29, 16'h0031);
    wait_valid(48, 8'h40, "R10 before drop");
    @(negedge clk);
    chip_rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 reset drop clears oe", 16'(data_oe), 16'h0);
    chip_rst = 1'b1;
    wait_valid(61, 8'h40, "R10 re-entry");
    @(negedge clk);
    psen_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 strobe release clears oe", 16'(data_oe), 16'h0);
    psen_n = 1'b0;
    wait_valid(61, 8'h40, "R10 strobe re-entry");
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_short_entry();
    t_code();
    t_gating();
    t_cfg();
    t_sig();
    t_lock();
    t_unmapped();
    t_drop();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule